// File: doc/BRIEF.md
# Trap Return State Update Unit

This unit executes the two privileged return operations of a hart that has an optional hypervisor extension: the return from a machine-level trap and the return from a supervisor-level trap. When the pipeline presents a return request, the unit looks at the current privilege, the virtualization flag, the relevant status and hypervisor-status fields and the two saved exception PCs. It then either commits the return or refuses it with an exception cause.

A committed return produces the updated interrupt-enable, previous-enable, previous-privilege and previous-virtualization fields, the privilege and virtualization mode to resume in, and the target PC. When a return re-enters a virtualized guest, the unit also issues a single-cycle request to exchange the banked hypervisor and guest registers. A refused return reports only the highest-priority cause and leaves every state output untouched. The CSR storage, the bank exchange itself and the fetch redirect belong to neighbouring blocks, which take the unit's outputs one cycle after the request.

Top module: `tret_unit`

## Requirements
- R1: A supervisor return at user privilege (0), and a machine return at any privilege other than machine (3), raise illegal instruction (cause 2).
- R2: With compressed support off, a return whose selected saved PC (mepc for machine, sepc for supervisor) has a nonzero value in bits [1:0] raises misaligned fetch (cause 0). With compressed support on, those bits are not checked and the saved PC is returned unchanged.
- R3: A supervisor return below machine privilege with the trap-return-to-supervisor bit set raises illegal instruction (cause 2).
- R4: A supervisor return with hypervisor support on, virtualization active and the guest trap-return bit set raises virtual instruction (cause 22).
- R5: The checks rank as follows: privilege first, then alignment, then the third check (R3 for supervisor returns, R9 for machine returns), then R4. Only the first failing check gives the cause.
- R6: A committed supervisor return sets SIE to the old SPIE, sets SPIE to 1, sets SPP to 0 and resumes at privilege 1 if the old SPP was 1 and at privilege 0 if it was 0. The machine fields pass through unchanged.
- R7: A committed supervisor return with hypervisor support on and virtualization off takes the new virtualization flag from SPV and clears SPV. In every other case it keeps the current flag and passes SPV through unchanged.
- R8: A committed machine return sets MIE to the old MPIE, sets MPIE to 1, sets MPP to 0, clears MPV and resumes at the privilege held in the old MPP. The supervisor fields pass through unchanged.
- R9: A machine return with no protection rules configured and an MPP other than 3 raises illegal instruction (cause 2).
- R10: A committed machine return takes the new virtualization flag from MPV when hypervisor support is on, and otherwise keeps the current flag.
- R11: The swap request pulses for exactly one cycle alongside a commit, and only when the new virtualization flag was captured from SPV or MPV and that captured bit is 1.
- R12: Results appear one clock after the request. Commit and exception pulses are never high together, nothing pulses without a request, and an exception or idle cycle leaves every state output and the return PC at their previous values.
- R13: After reset the pulses and all status outputs are 0, the return PC is 0 and the privilege output is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retReq | input | 1 | Return request, one cycle per return |
| retIsMachine | input | 1 | 1 = machine return, 0 = supervisor return |
| curPriv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| curVirt | input | 1 | Current virtualization flag |
| extCompressed | input | 1 | Compressed instruction support enabled |
| extHyp | input | 1 | Hypervisor support enabled |
| protRulesOn | input | 1 | At least one memory protection rule configured |
| inSie | input | 1 | Status supervisor interrupt enable |
| inSpie | input | 1 | Status supervisor previous enable |
| inSpp | input | 1 | Status supervisor previous privilege |
| inMie | input | 1 | Status machine interrupt enable |
| inMpie | input | 1 | Status machine previous enable |
| inMpp | input | 2 | Status machine previous privilege |
| inMpv | input | 1 | Status machine previous virtualization |
| inTsr | input | 1 | Status trap-return-to-supervisor bit |
| inSpv | input | 1 | Hypervisor-status supervisor previous virtualization |
| inVtsr | input | 1 | Hypervisor-status guest trap-return bit |
| sepcIn | input | XLEN | Supervisor saved exception PC |
| mepcIn | input | XLEN | Machine saved exception PC |
| doneValid | output | 1 | Return committed (one-cycle pulse) |
| excValid | output | 1 | Return refused (one-cycle pulse) |
| excCause | output | 5 | Cause of the last refused return |
| outSie | output | 1 | Updated SIE |
| outSpie | output | 1 | Updated SPIE |
| outSpp | output | 1 | Updated SPP |
| outMie | output | 1 | Updated MIE |
| outMpie | output | 1 | Updated MPIE |
| outMpp | output | 2 | Updated MPP |
| outMpv | output | 1 | Updated MPV |
| outSpv | output | 1 | Updated SPV |
| newPriv | output | 2 | Privilege to resume in |
| newVirt | output | 1 | Virtualization flag to resume with |
| retPc | output | XLEN | Return target PC |
| swapReq | output | 1 | Register bank exchange request pulse |

## Verification
The bench sweeps all combinations of return kind, privilege, virtualization, extension enables, low PC bits, the two trap bits, the protection flag, MPP, SPP, SPV and MPV. It targets cases where several checks fail at once. A design with the priority wrong would report misaligned fetch for a user-mode supervisor return at an odd PC, or virtual instruction where a trap-return trap applies. It also goes after the hypervisor branches. A design that restored SPV while virtualized, or that swapped banks without hypervisor support, would show a wrong newVirt or a spurious swapReq. Refused and idle cycles are checked to leave the state outputs unchanged, which catches a design that commits a partial update on an exception.

// File: rtl/tret_pkg.sv
`timescale 1ns/1ps
package tret_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

  // strobes from control to datapath
  typedef struct packed {
    logic                commit;
    logic                raise;
    logic                machineKind;
    logic                takeVirt;
    logic [CAUSE_W-1:0]  cause;
  } tretStrobe_t;
endpackage

// File: rtl/tret_ctrl.sv
`timescale 1ns/1ps
module tret_ctrl
  import tret_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        retReq,
  input  logic        retIsMachine,
  input  logic [1:0]  curPriv,
  input  logic        curVirt,
  input  logic        extCompressed,
  input  logic        extHyp,
  input  logic        protRulesOn,
  input  logic        inTsr,
  input  logic        inVtsr,
  input  logic [1:0]  inMpp,
  input  logic [1:0]  sepcLow,
  input  logic [1:0]  mepcLow,
  output tretStrobe_t strb
);
  localparam int NCHK = 4;

  logic [NCHK-1:0]    failVec;
  logic [CAUSE_W-1:0] causeVec [NCHK];
  logic [1:0]         selLow;
  logic               anyFail;

  assign selLow = retIsMachine ? mepcLow : sepcLow;

  // index 0 has the highest priority
  always_comb begin
    failVec[0]  = retIsMachine ? (curPriv != PRIV_M) : (curPriv < PRIV_S);
    causeVec[0] = CAUSE_ILLEGAL;
    failVec[1]  = !extCompressed && (selLow != 2'b00);
    causeVec[1] = CAUSE_MISALIGN;
    failVec[2]  = retIsMachine ? (!protRulesOn && (inMpp != PRIV_M))
                               : (inTsr && (curPriv < PRIV_M));
    causeVec[2] = CAUSE_ILLEGAL;
    failVec[3]  = !retIsMachine && extHyp && curVirt && inVtsr;
    causeVec[3] = CAUSE_VIRT;
  end

  always_comb begin
    anyFail = |failVec;
    strb.cause = '0;
    for (int k = NCHK-1; k >= 0; k--) begin
      if (failVec[k]) strb.cause = causeVec[k];
    end
    strb.raise       = retReq && anyFail;
    strb.commit      = retReq && !anyFail;
    strb.machineKind = retIsMachine;
    strb.takeVirt    = extHyp && (retIsMachine || !curVirt);
  end

  // commit and raise are exclusive (R12)
  p_excl_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.commit, strb.raise}));

  // supervisor trap bit blocks a supervisor-mode return (R3)
  p_tsr_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !retIsMachine && curPriv == PRIV_S && inTsr) |-> !strb.commit);
endmodule

// File: rtl/tret_dpath.sv
`timescale 1ns/1ps
module tret_dpath
  import tret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  tretStrobe_t        strb,
  input  logic               curVirt,
  input  logic               inSie,
  input  logic               inSpie,
  input  logic               inSpp,
  input  logic               inMie,
  input  logic               inMpie,
  input  logic [1:0]         inMpp,
  input  logic               inMpv,
  input  logic               inSpv,
  input  logic [XLEN-1:0]    sepcIn,
  input  logic [XLEN-1:0]    mepcIn,
  output logic               doneValid,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic               outSie,
  output logic               outSpie,
  output logic               outSpp,
  output logic               outMie,
  output logic               outMpie,
  output logic [1:0]         outMpp,
  output logic               outMpv,
  output logic               outSpv,
  output logic [1:0]         newPriv,
  output logic               newVirt,
  output logic [XLEN-1:0]    retPc,
  output logic               swapReq
);
  logic            nSie, nSpie, nSpp, nMie, nMpie, nMpv, nSpv, nVirt, capVirt;
  logic [1:0]      nMpp, nPriv;
  logic [XLEN-1:0] nPc;

  always_comb begin
    nSie  = inSie;  nSpie = inSpie; nSpp = inSpp;
    nMie  = inMie;  nMpie = inMpie; nMpp = inMpp;
    nMpv  = inMpv;  nSpv  = inSpv;
    nVirt = curVirt;
    if (strb.machineKind) begin
      capVirt = inMpv;
      nMie    = inMpie;
      nMpie   = 1'b1;
      nMpp    = PRIV_U;
      nMpv    = 1'b0;
      nPriv   = inMpp;
      nPc     = mepcIn;
    end else begin
      capVirt = inSpv;
      nSie    = inSpie;
      nSpie   = 1'b1;
      nSpp    = 1'b0;
      nPriv   = inSpp ? PRIV_S : PRIV_U;
      nPc     = sepcIn;
      if (strb.takeVirt) nSpv = 1'b0;
    end
    if (strb.takeVirt) nVirt = capVirt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0; excValid <= 1'b0; swapReq <= 1'b0;
      excCause  <= '0;
      outSie <= 1'b0; outSpie <= 1'b0; outSpp <= 1'b0;
      outMie <= 1'b0; outMpie <= 1'b0; outMpp <= PRIV_U;
      outMpv <= 1'b0; outSpv  <= 1'b0;
      newPriv <= PRIV_M; newVirt <= 1'b0; retPc <= '0;
    end else begin
      doneValid <= strb.commit;
      excValid  <= strb.raise;
      swapReq   <= strb.commit && strb.takeVirt && capVirt;
      if (strb.raise) excCause <= strb.cause;
      if (strb.commit) begin
        outSie <= nSie; outSpie <= nSpie; outSpp <= nSpp;
        outMie <= nMie; outMpie <= nMpie; outMpp <= nMpp;
        outMpv <= nMpv; outSpv  <= nSpv;
        newPriv <= nPriv; newVirt <= nVirt; retPc <= nPc;
      end
    end
  end

  // the swap only accompanies a commit (R11)
  p_swap_with_commit_r11: assert property (@(posedge clk) disable iff (!rstN)
    swapReq |-> doneValid && newVirt);

  // refused or idle cycles keep state (R12)
  p_hold_state_r12: assert property (@(posedge clk) disable iff (!rstN)
    !doneValid |-> $stable(newPriv) && $stable(retPc) && $stable(newVirt));
endmodule

// File: rtl/tret_unit.sv
`timescale 1ns/1ps
module tret_unit
  import tret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               retReq,
  input  logic               retIsMachine,
  input  logic [1:0]         curPriv,
  input  logic               curVirt,
  input  logic               extCompressed,
  input  logic               extHyp,
  input  logic               protRulesOn,
  input  logic               inSie,
  input  logic               inSpie,
  input  logic               inSpp,
  input  logic               inMie,
  input  logic               inMpie,
  input  logic [1:0]         inMpp,
  input  logic               inMpv,
  input  logic               inTsr,
  input  logic               inSpv,
  input  logic               inVtsr,
  input  logic [XLEN-1:0]    sepcIn,
  input  logic [XLEN-1:0]    mepcIn,
  output logic               doneValid,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic               outSie,
  output logic               outSpie,
  output logic               outSpp,
  output logic               outMie,
  output logic               outMpie,
  output logic [1:0]         outMpp,
  output logic               outMpv,
  output logic               outSpv,
  output logic [1:0]         newPriv,
  output logic               newVirt,
  output logic [XLEN-1:0]    retPc,
  output logic               swapReq
);
  tretStrobe_t strb;

  tret_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .retReq(retReq), .retIsMachine(retIsMachine),
    .curPriv(curPriv), .curVirt(curVirt), .extCompressed(extCompressed),
    .extHyp(extHyp), .protRulesOn(protRulesOn), .inTsr(inTsr),
    .inVtsr(inVtsr), .inMpp(inMpp), .sepcLow(sepcIn[1:0]),
    .mepcLow(mepcIn[1:0]), .strb(strb)
  );

  tret_dpath #(.XLEN(XLEN)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .curVirt(curVirt),
    .inSie(inSie), .inSpie(inSpie), .inSpp(inSpp), .inMie(inMie),
    .inMpie(inMpie), .inMpp(inMpp), .inMpv(inMpv), .inSpv(inSpv),
    .sepcIn(sepcIn), .mepcIn(mepcIn),
    .doneValid(doneValid), .excValid(excValid), .excCause(excCause),
    .outSie(outSie), .outSpie(outSpie), .outSpp(outSpp), .outMie(outMie),
    .outMpie(outMpie), .outMpp(outMpp), .outMpv(outMpv), .outSpv(outSpv),
    .newPriv(newPriv), .newVirt(newVirt), .retPc(retPc), .swapReq(swapReq)
  );

  // privilege check reports illegal instruction (R1)
  p_priv_illegal_r1: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && (retIsMachine ? (curPriv != PRIV_M) : (curPriv == PRIV_U)))
    |=> excValid && excCause == CAUSE_ILLEGAL);

  // misaligned target when compressed support is off (R2)
  p_misalign_r2: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !extCompressed && (curPriv == PRIV_M) &&
     ((retIsMachine ? mepcIn[1:0] : sepcIn[1:0]) != 2'b00))
    |=> excValid && excCause == CAUSE_MISALIGN);

  // supervisor return leaves SPIE set and SPP cleared (R6)
  p_sret_fields_r6: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !retIsMachine) |=> (doneValid |-> outSpie && !outSpp));

  // machine return leaves MPIE set, MPP user, MPV cleared (R8)
  p_mret_fields_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && retIsMachine) |=> (doneValid |-> outMpie && outMpp == PRIV_U && !outMpv));

  // no pulse without a request (R12)
  p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rstN)
    !retReq |=> !doneValid && !excValid && !swapReq);
endmodule

// File: tb/tret_unit_test.sv
`timescale 1ns/1ps
module tret_unit_test;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retReq = 0, retIsMachine = 0, curVirt = 0, extCompressed = 0, extHyp = 0;
  logic protRulesOn = 0, inSie = 0, inSpie = 0, inSpp = 0, inMie = 0, inMpie = 0;
  logic inMpv = 0, inTsr = 0, inSpv = 0, inVtsr = 0;
  logic [1:0] curPriv = 0, inMpp = 0;
  logic [XLEN-1:0] sepcIn = 0, mepcIn = 0;
  logic doneValid, excValid, outSie, outSpie, outSpp, outMie, outMpie, outMpv;
  logic outSpv, newVirt, swapReq;
  logic [4:0] excCause;
  logic [1:0] outMpp, newPriv;
  logic [XLEN-1:0] retPc;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tret_unit #(.XLEN(XLEN)) uut (.*);

  // expected architectural outputs
  logic eSie = 0, eSpie = 0, eSpp = 0, eMie = 0, eMpie = 0, eMpv = 0, eSpv = 0, eVirt = 0;
  logic [1:0] eMpp = 0, ePriv = 2'd3;
  logic [XLEN-1:0] ePc = 0;
  logic [4:0] eCause = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkState(input string req);
    chk(req, "sie", outSie, eSie);    chk(req, "spie", outSpie, eSpie);
    chk(req, "spp", outSpp, eSpp);    chk(req, "mie", outMie, eMie);
    chk(req, "mpie", outMpie, eMpie); chk(req, "mpp", outMpp, eMpp);
    chk(req, "mpv", outMpv, eMpv);    chk(req, "spv", outSpv, eSpv);
    chk(req, "priv", newPriv, ePriv); chk(req, "virt", newVirt, eVirt);
    chk(req, "pc", retPc, ePc);
  endtask

  task automatic runVec(input int i);
    logic k, v, h, c, t, vt, p, sp, spv, mpv, spie, mpie, sie, mie;
    logic [1:0] pr, lo, mpp;
    logic f0, f1, f2, f3, expExc, expSwap, takeV;
    int nf;
    string tag;
    logic [4:0] cause;
    logic [XLEN-1:0] sepc, mepc;
    k = i[0]; pr = i[2:1]; v = i[3]; h = i[4]; c = i[5]; lo = i[7:6];
    t = i[8]; vt = i[9]; p = i[10]; mpp = i[12:11]; sp = i[13];
    spv = i[14]; mpv = i[15];
    spie = i[0] ^ i[5]; sie = i[3] ^ i[9]; mpie = i[2] ^ i[7]; mie = i[1] ^ i[11];
    sepc = 32'h1000_0000 | (XLEN'(i) << 4) | XLEN'(lo);
    mepc = 32'h8000_0000 | (XLEN'(i) << 4) | XLEN'(lo);
    retReq = 1; retIsMachine = k; curPriv = pr; curVirt = v; extHyp = h;
    extCompressed = c; inTsr = t; inVtsr = vt; protRulesOn = p; inMpp = mpp;
    inSpp = sp; inSpv = spv; inMpv = mpv; inSpie = spie; inSie = sie;
    inMpie = mpie; inMie = mie; sepcIn = sepc; mepcIn = mepc;
    // expected checks, in priority order (R5)
    f0 = k ? (pr != 2'd3) : (pr == 2'd0);
    f1 = !c && (lo != 2'd0);
    f2 = k ? (!p && mpp != 2'd3) : (t && pr != 2'd3);
    f3 = !k && h && v && vt;
    nf = int'(f0) + int'(f1) + int'(f2) + int'(f3);
    expExc = f0 | f1 | f2 | f3;
    if (f0)      begin cause = 5'd2;  tag = "R1"; end
    else if (f1) begin cause = 5'd0;  tag = "R2"; end
    else if (f2) begin cause = 5'd2;  tag = k ? "R9" : "R3"; end
    else         begin cause = 5'd22; tag = "R4"; end
    if (nf > 1) tag = "R5";
    takeV = h && (k || !v);
    expSwap = 0;
    if (!expExc) begin
      if (k) begin
        eMie = mpie; eMpie = 1; eMpp = 0; eMpv = 0; ePriv = mpp; ePc = mepc;
        eSie = sie; eSpie = spie; eSpp = sp; eSpv = spv;
        eVirt = takeV ? mpv : v; expSwap = takeV && mpv;
      end else begin
        eSie = spie; eSpie = 1; eSpp = 0; ePriv = sp ? 2'd1 : 2'd0; ePc = sepc;
        eMie = mie; eMpie = mpie; eMpp = mpp; eMpv = mpv;
        eSpv = takeV ? 1'b0 : spv; eVirt = takeV ? spv : v; expSwap = takeV && spv;
      end
    end else begin
      eCause = cause;
    end
    @(negedge clk);
    retReq = 0;
    if (expExc) begin
      chk(tag, "excValid", excValid, 1);
      chk(tag, "excCause", excCause, cause);
      chk("R12", "doneValid on refuse", doneValid, 0);
      chk("R12", "swap on refuse", swapReq, 0);
      chk("R12", "hold priv", newPriv, ePriv);
      chk("R12", "hold pc", retPc, ePc);
      chk("R12", "hold mpp", outMpp, eMpp);
      chk("R12", "hold virt", newVirt, eVirt);
    end else begin
      chk(k ? "R8" : "R6", "doneValid", doneValid, 1);
      chk("R12", "excValid on commit", excValid, 0);
      chkState(k ? "R8" : "R6");
      chk(k ? "R10" : "R7", "newVirt", newVirt, eVirt);
      chk("R11", "swapReq", swapReq, expSwap);
      chk("R2", "retPc", retPc, ePc);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // reset state (R13)
    chk("R13", "doneValid", doneValid, 0);
    chk("R13", "excValid", excValid, 0);
    chk("R13", "swapReq", swapReq, 0);
    chk("R13", "excCause", excCause, 0);
    chkState("R13");
    rstN = 1;
    @(negedge clk);
    for (int i = 0; i < 65536; i++) runVec(i);
    // idle cycles with changing inputs change nothing (R12)
    for (int j = 0; j < 4; j++) begin
      retIsMachine = j[0]; curPriv = 2'd3; inMpp = 2'd1; inSpie = 1; inMpie = 1;
      extCompressed = 1; protRulesOn = 1; sepcIn = 32'h55; mepcIn = 32'h77;
      @(negedge clk);
      chk("R12", "idle doneValid", doneValid, 0);
      chk("R12", "idle excValid", excValid, 0);
      chk("R12", "idle swapReq", swapReq, 0);
      chk("R12", "idle cause", excCause, eCause);
      chkState("R12");
    end
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule